// File: doc/BRIEF.md
# LIN Header Supervisor

This block sits beside the byte receiver of a LIN slave node and follows each incoming header: the break, the synch byte and the identifier byte. It looks at the receive line once per bit time to find breaks. It takes status strobes from the byte receiver for the synch and identifier bytes. From the moment a break is found, it counts the header length in bit times.

A header that runs longer than the allowed budget is abandoned and flagged as a timeout. A header that completes has its measured length placed in a readable register. While the receiver is muted, a clean header produces a one-cycle wake-up pulse. Synch errors and timeouts raise the header-error flag and never wake the receiver. Framing faults on ordinary data bytes are dropped in mute mode. A parity error on the identifier does not stop the wake-up.

Top module: `lin_hdr_supervisor`

## Requirements
- R1: A break is recognised on a bit tick that samples the line recessive (1) after at least 11 consecutive dominant (0) samples. A run of 10 dominant bits starts no header, and synch or identifier strobes that follow it have no effect.
- R2: The header length is counted in bit ticks, starting from the first dominant bit of the break and including the recessive delimiter. When the identifier completes, the count is copied into `hdr_len`, whether or not a timeout occurred.
- R3: A header of exactly 57 bit times completes without timeout. On the tick that would take the length to 58 or more, the block sets `hdr_timeout` and `hdr_err`, loads that length into `hdr_len` and drops the header.
- R4: `wake_pulse` is high for exactly one cycle after an accepted header, and only when `mute_en` was high. It never fires outside mute mode.
- R5: A synch deviation strobe during the synch phase sets `hdr_err` and drops the header. A later identifier strobe then produces no wake-up.
- R6: An identifier parity error does not prevent wake-up. It sets `id_parity_flag` when the header is accepted.
- R7: An identifier framing error rejects the header, so there is no wake-up. In mute mode it leaves `frame_err` clear. Outside mute mode it sets `frame_err`.
- R8: A framing error on an ordinary data byte sets `frame_err` outside mute mode. In mute mode it is dropped.
- R9: A new break detected in the middle of a header restarts the header. The length count is reseeded from the new break.
- R10: The length counter saturates at 2^LEN_W-1 (255 by default). A break of 300 dominant bits followed by one more tick reports length 255 together with a timeout.
- R11: The flags are sticky. `flag_clr` clears them on a write of one, with bit 0 for `hdr_err`, bit 1 for `hdr_timeout`, bit 2 for `frame_err` and bit 3 for `id_parity_flag`. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time; the line is sampled on it |
| rx_line | input | 1 | Received line level, 0 = dominant |
| mute_en | input | 1 | Receiver is in mute mode |
| sync_ok | input | 1 | Synch byte measured within tolerance (strobe) |
| sync_dev_err | input | 1 | Synch byte deviation error (strobe) |
| id_done | input | 1 | Identifier byte received (strobe) |
| id_frame_err | input | 1 | Identifier had a framing error, qualified by id_done |
| id_parity_err | input | 1 | Identifier parity error, qualified by id_done |
| data_frame_err | input | 1 | Framing error on an ordinary data byte (strobe) |
| flag_clr | input | 4 | Write-one-to-clear strobes for the four flags |
| wake_pulse | output | 1 | One-cycle wake-up from mute |
| hdr_err | output | 1 | Sticky header error |
| hdr_timeout | output | 1 | Sticky header timeout |
| frame_err | output | 1 | Sticky framing error |
| id_parity_flag | output | 1 | Sticky identifier parity error |
| hdr_len | output | LEN_W | Length in bit times of the last completed or aborted header |

## Verification
The bench runs headers of exactly 57 and 58 bit times. A design with an off-by-one in the limit would either time out a legal header or wake on an overlong one. It sends a 10-bit dominant run and follows it with strobes, which a loose break detector would take as a header. It also sends a strobe after a synch error or a timeout, which a design that forgets to drop the header would turn into a wake. Further cases are a break in the middle of a header (a wrong reseed shows up as a wrong length), a 300-bit break (a wrapping counter reports a small length), and parity and framing faults in both modes, which catch wrong mute filtering.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_ID   = 2'd2
  } hdr_state_e;

  localparam int unsigned NUM_FLAGS   = 4;
  localparam int unsigned FLG_HDR_ERR = 0;
  localparam int unsigned FLG_TIMEOUT = 1;
  localparam int unsigned FLG_FRAME   = 2;
  localparam int unsigned FLG_PARITY  = 3;

endpackage

// File: rtl/lin_brk_detect.sv
module lin_brk_detect #(
  parameter int unsigned DOM_W   = 8,
  parameter int unsigned BRK_MIN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  output logic             brk_hit,
  output logic [DOM_W-1:0] brk_bits
);

  localparam logic [DOM_W-1:0] DOM_MAX = {DOM_W{1'b1}};
  localparam logic [DOM_W-1:0] MIN_L   = DOM_W'(BRK_MIN);

  logic [DOM_W-1:0] dom_q;
  logic [DOM_W-1:0] dom_d;

  // run-length of dominant samples; a recessive sample closes the run
  always_comb begin
    dom_d   = dom_q;
    brk_hit = 1'b0;
    if (bit_tick) begin
      if (!rx_line) begin
        dom_d = (dom_q == DOM_MAX) ? dom_q : dom_q + 1'b1;
      end else begin
        brk_hit = (dom_q >= MIN_L);
        dom_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= '0;
    end else if (bit_tick) begin
      dom_q <= dom_d;
    end
  end

  assign brk_bits = dom_q;

endmodule

// File: rtl/lin_hdr_timer.sv
module lin_hdr_timer #(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned DOM_W     = 8,
  parameter int unsigned HDR_LIMIT = 57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             active,
  input  logic             brk_hit,
  input  logic [DOM_W-1:0] brk_bits,
  input  logic             hdr_done,
  output logic             to_hit,
  output logic [LEN_W-1:0] hdr_len
);

  localparam int unsigned     SW      = ((LEN_W > DOM_W) ? LEN_W : DOM_W) + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LIMIT_L = LEN_W'(HDR_LIMIT);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cnt_inc;
  logic [LEN_W-1:0] seed;
  logic [SW-1:0]    seed_w;

  // seed = break length plus its delimiter, saturated to the counter width
  always_comb begin
    seed_w = SW'(brk_bits) + SW'(1);
    seed   = (seed_w > SW'(LEN_MAX)) ? LEN_MAX : seed_w[LEN_W-1:0];
  end

  always_comb begin
    cnt_inc = (cnt_q == LEN_MAX) ? cnt_q : cnt_q + 1'b1;
    to_hit  = active && bit_tick && !brk_hit && !hdr_done && (cnt_inc > LIMIT_L);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (brk_hit) begin
      cnt_d = seed;
    end else if (active && bit_tick) begin
      cnt_d = cnt_inc;
    end
  end

  always_comb begin
    len_d = len_q;
    if (hdr_done) begin
      len_d = cnt_q;
    end else if (to_hit) begin
      len_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (brk_hit || (active && bit_tick)) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (hdr_done || to_hit) begin
      len_q <= len_d;
    end
  end

  assign hdr_len = len_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LEN_MAX && !brk_hit) |=> (cnt_q == LEN_MAX));  // R10

endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
  import lin_hdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 brk_hit,
  input  logic                 to_hit,
  input  logic                 mute_en,
  input  logic                 sync_ok,
  input  logic                 sync_dev_err,
  input  logic                 id_done,
  input  logic                 id_frame_err,
  input  logic                 id_parity_err,
  input  logic                 data_frame_err,
  output logic                 active,
  output logic                 hdr_done,
  output logic                 wake_pulse,
  output logic [NUM_FLAGS-1:0] flag_set
);

  hdr_state_e state_q, state_d;
  logic       wake_q, wake_d;
  logic       sync_fail;
  logic       accept;

  always_comb begin
    hdr_done  = (state_q == ST_ID) && id_done && !brk_hit;
    sync_fail = (state_q == ST_SYNC) && sync_dev_err && !brk_hit && !to_hit;
    accept    = hdr_done && !id_frame_err;
    active    = (state_q != ST_HUNT);
  end

  always_comb begin
    state_d = state_q;
    if (brk_hit) begin
      state_d = ST_SYNC;
    end else if (to_hit) begin
      state_d = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_SYNC: begin
          if (sync_dev_err)  state_d = ST_HUNT;
          else if (sync_ok)  state_d = ST_ID;
        end
        ST_ID: begin
          if (id_done)       state_d = ST_HUNT;
        end
        default:             state_d = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    flag_set              = '0;
    flag_set[FLG_HDR_ERR] = to_hit || sync_fail;
    flag_set[FLG_TIMEOUT] = to_hit;
    flag_set[FLG_FRAME]   = !mute_en && (data_frame_err || (hdr_done && id_frame_err));
    flag_set[FLG_PARITY]  = accept && id_parity_err;
    wake_d                = accept && mute_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign wake_pulse = wake_q;

  AST_WAKE_FROM_ID: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> ($past(state_q) == ST_ID));  // R4

endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      flag_d = set_i[i] | (flag_q & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (set_i[i] || clr_i[i]) begin
        flag_q <= flag_d;
      end
    end

    assign flags[i] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q);  // R11
  end

endmodule

// File: rtl/lin_hdr_supervisor.sv
module lin_hdr_supervisor
  import lin_hdr_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned DOM_W     = 8,
  parameter int unsigned BRK_MIN   = 11,
  parameter int unsigned HDR_LIMIT = 57
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic             mute_en,
  input  logic             sync_ok,
  input  logic             sync_dev_err,
  input  logic             id_done,
  input  logic             id_frame_err,
  input  logic             id_parity_err,
  input  logic             data_frame_err,
  input  logic [3:0]       flag_clr,
  output logic             wake_pulse,
  output logic             hdr_err,
  output logic             hdr_timeout,
  output logic             frame_err,
  output logic             id_parity_flag,
  output logic [LEN_W-1:0] hdr_len
);

  localparam logic [LEN_W-1:0] LIMIT_L = LEN_W'(HDR_LIMIT);

  logic                 brk_hit;
  logic [DOM_W-1:0]     brk_bits;
  logic                 to_hit;
  logic                 active;
  logic                 hdr_done;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags;

  lin_brk_detect #(.DOM_W(DOM_W), .BRK_MIN(BRK_MIN)) u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .rx_line  (rx_line),
    .brk_hit  (brk_hit),
    .brk_bits (brk_bits)
  );

  lin_hdr_timer #(.LEN_W(LEN_W), .DOM_W(DOM_W), .HDR_LIMIT(HDR_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .active   (active),
    .brk_hit  (brk_hit),
    .brk_bits (brk_bits),
    .hdr_done (hdr_done),
    .to_hit   (to_hit),
    .hdr_len  (hdr_len)
  );

  lin_hdr_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .brk_hit        (brk_hit),
    .to_hit         (to_hit),
    .mute_en        (mute_en),
    .sync_ok        (sync_ok),
    .sync_dev_err   (sync_dev_err),
    .id_done        (id_done),
    .id_frame_err   (id_frame_err),
    .id_parity_err  (id_parity_err),
    .data_frame_err (data_frame_err),
    .active         (active),
    .hdr_done       (hdr_done),
    .wake_pulse     (wake_pulse),
    .flag_set       (flag_set)
  );

  lin_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .flags (flags)
  );

  assign hdr_err        = flags[FLG_HDR_ERR];
  assign hdr_timeout    = flags[FLG_TIMEOUT];
  assign frame_err      = flags[FLG_FRAME];
  assign id_parity_flag = flags[FLG_PARITY];

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);  // R4

  AST_WAKE_MUTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(mute_en));  // R4

  AST_TIMEOUT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_timeout) |-> (hdr_len > LIMIT_L));  // R3

  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_timeout) |-> hdr_err);  // R3

  AST_MUTE_NO_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && !frame_err) |=> !frame_err);  // R8

endmodule

// File: tb/lin_hdr_supervisor_tb.sv
module lin_hdr_supervisor_tb;

  localparam int F_WAKE = 0, F_HERR = 1, F_TO = 2, F_FE = 3, F_PAR = 4, F_LEN = 5;

  typedef struct {
    string req;
    int    field;
    int    exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick, rx_line, mute_en, sync_ok, sync_dev_err;
  logic       id_done, id_frame_err, id_parity_err, data_frame_err;
  logic [3:0] flag_clr;
  logic       wake_pulse, hdr_err, hdr_timeout, frame_err, id_parity_flag;
  logic [7:0] hdr_len;

  item_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  int    wake_seen = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  lin_hdr_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .mute_en(mute_en), .sync_ok(sync_ok), .sync_dev_err(sync_dev_err),
    .id_done(id_done), .id_frame_err(id_frame_err), .id_parity_err(id_parity_err),
    .data_frame_err(data_frame_err), .flag_clr(flag_clr),
    .wake_pulse(wake_pulse), .hdr_err(hdr_err), .hdr_timeout(hdr_timeout),
    .frame_err(frame_err), .id_parity_flag(id_parity_flag), .hdr_len(hdr_len)
  );

  // monitor: counts wake pulses and compares queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wake_pulse) wake_seen++;
      while (sb_q.size() > 0) begin
        item_t it;
        int    act;
        it = sb_q.pop_front();
        case (it.field)
          F_WAKE: begin act = wake_seen; wake_seen = 0; end
          F_HERR: act = int'(hdr_err);
          F_TO:   act = int'(hdr_timeout);
          F_FE:   act = int'(frame_err);
          F_PAR:  act = int'(id_parity_flag);
          default: act = int'(hdr_len);
        endcase
        checks++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s field %0d: actual %0d expected %0d", it.req, it.field, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input string req, input int field, input int exp);
    item_t it;
    it.req = req; it.field = field; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk); rx_line = v; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic send_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) send_bit(v);
  endtask

  task automatic do_sync(input logic err);
    @(negedge clk); sync_ok = !err; sync_dev_err = err;
    @(negedge clk); sync_ok = 1'b0; sync_dev_err = 1'b0;
  endtask

  task automatic do_id(input logic fe, input logic pe);
    @(negedge clk); id_done = 1'b1; id_frame_err = fe; id_parity_err = pe;
    @(negedge clk); id_done = 1'b0; id_frame_err = 1'b0; id_parity_err = 1'b0;
  endtask

  task automatic do_data_fe();
    @(negedge clk); data_frame_err = 1'b1;
    @(negedge clk); data_frame_err = 1'b0;
  endtask

  task automatic do_clr(input logic [3:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 4'h0;
  endtask

  task automatic header(input int nbrk, input int nsync, input logic serr,
                        input int nid, input logic fe, input logic pe);
    send_bits(nbrk, 1'b0);
    send_bit(1'b1);
    send_bits(nsync, 1'b1);
    do_sync(serr);
    send_bits(nid, 1'b1);
    do_id(fe, pe);
    idle(3);
  endtask

  task automatic settle();
    idle(3);
    wait (sb_q.size() == 0);
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_tick = 0; rx_line = 1; mute_en = 0; sync_ok = 0; sync_dev_err = 0;
    id_done = 0; id_frame_err = 0; id_parity_err = 0; data_frame_err = 0; flag_clr = 0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // reset state
    expect_item("R11 reset hdr_err", F_HERR, 0);
    expect_item("R11 reset timeout", F_TO, 0);
    expect_item("R2 reset length", F_LEN, 0);
    expect_item("R4 reset wake", F_WAKE, 0);
    settle();

    // R2/R4: valid muted header, 13-bit break -> 14 + 10 + 10 = 34
    mute_en = 1'b1;
    header(13, 10, 1'b0, 10, 1'b0, 1'b0);
    expect_item("R4 wake on valid header", F_WAKE, 1);
    expect_item("R2 header length 34", F_LEN, 34);
    expect_item("R3 no timeout at 34", F_TO, 0);
    settle();

    // R3: exactly 57 bit times
    header(11, 20, 1'b0, 25, 1'b0, 1'b0);
    expect_item("R3 wake at 57", F_WAKE, 1);
    expect_item("R3 length 57", F_LEN, 57);
    expect_item("R3 no timeout at 57", F_TO, 0);
    settle();

    // R3: 58 bit times -> timeout, no wake, late id ignored
    header(11, 20, 1'b0, 26, 1'b0, 1'b0);
    expect_item("R3 no wake on timeout", F_WAKE, 0);
    expect_item("R3 timeout flag", F_TO, 1);
    expect_item("R3 hdr_err on timeout", F_HERR, 1);
    expect_item("R3 length 58", F_LEN, 58);
    settle();

    // R11: clear only bit0
    do_clr(4'b0001);
    expect_item("R11 hdr_err cleared", F_HERR, 0);
    expect_item("R11 timeout kept", F_TO, 1);
    settle();
    do_clr(4'hF);
    expect_item("R11 timeout cleared", F_TO, 0);
    settle();

    // R1: 10 dominant bits is no break
    header(10, 5, 1'b0, 5, 1'b0, 1'b0);
    expect_item("R1 short break no wake", F_WAKE, 0);
    expect_item("R1 short break length unchanged", F_LEN, 58);
    expect_item("R1 short break no error", F_HERR, 0);
    settle();

    // R5: synch deviation in mute
    header(12, 5, 1'b1, 5, 1'b0, 1'b0);
    expect_item("R5 no wake after synch error", F_WAKE, 0);
    expect_item("R5 hdr_err set", F_HERR, 1);
    expect_item("R5 no timeout", F_TO, 0);
    expect_item("R5 length unchanged", F_LEN, 58);
    settle();
    do_clr(4'hF);

    // R6: parity error still wakes
    header(11, 8, 1'b0, 9, 1'b0, 1'b1);
    expect_item("R6 wake despite parity", F_WAKE, 1);
    expect_item("R6 parity flag", F_PAR, 1);
    expect_item("R6 length 29", F_LEN, 29);
    settle();
    do_clr(4'hF);

    // R7: identifier framing error in mute
    header(11, 8, 1'b0, 9, 1'b1, 1'b0);
    expect_item("R7 no wake on id framing", F_WAKE, 0);
    expect_item("R7 no frame flag in mute", F_FE, 0);
    settle();

    // R8: data framing error in mute dropped
    do_data_fe();
    expect_item("R8 mute drops data framing", F_FE, 0);
    settle();

    // R8: outside mute it is flagged
    mute_en = 1'b0;
    do_data_fe();
    expect_item("R8 data framing flagged", F_FE, 1);
    settle();
    do_clr(4'b0100);
    expect_item("R11 frame flag cleared", F_FE, 0);
    settle();

    // R7: id framing outside mute sets flag; R4: valid header outside mute no wake
    header(11, 4, 1'b0, 4, 1'b1, 1'b0);
    expect_item("R7 frame flag outside mute", F_FE, 1);
    settle();
    header(14, 6, 1'b0, 6, 1'b0, 1'b0);
    expect_item("R4 no wake outside mute", F_WAKE, 0);
    expect_item("R2 length 27 outside mute", F_LEN, 27);
    settle();
    do_clr(4'hF);

    // R9: break in middle of identifier phase restarts header
    mute_en = 1'b1;
    send_bits(11, 1'b0); send_bit(1'b1); send_bits(5, 1'b1); do_sync(1'b0);
    send_bits(3, 1'b1);
    header(12, 3, 1'b0, 4, 1'b0, 1'b0);
    expect_item("R9 single wake after restart", F_WAKE, 1);
    expect_item("R9 length reseeded 20", F_LEN, 20);
    expect_item("R9 no timeout", F_TO, 0);
    settle();

    // R10: 300-bit break saturates
    send_bits(300, 1'b0); send_bit(1'b1); send_bit(1'b1);
    idle(3);
    expect_item("R10 saturated length", F_LEN, 255);
    expect_item("R10 timeout on saturated", F_TO, 1);
    expect_item("R10 no wake", F_WAKE, 0);
    settle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule